// File: doc/BRIEF.md
# Serial Clock Divider With Safe-Stop Handshake

This block derives the serial interface clock from the controller clock. A two-bit field selects a power-of-two division ratio of 1, 2, 4 or 8, and either of two enable bits lets the clock run. The clock starts and stops only at a period boundary. A stopped flag reports when the output is parked low, so software can change the settings safely.

Software uses a handshake. It clears both enables and polls the status word until the engine is idle, both bus-activity flags are low and the clock-stopped flag is high. It then writes the new divider and phase, sets an enable again and waits for the stopped flag to fall. The divider and phase fields are locked whenever the clock is not fully stopped. The phase bit is stored and read back, but only the 180-degree behaviour (value 0) is implemented. The block ends at the clock and the status word; it contains no transfer engine or delay line.

Top module: `sclk_divider`

## Requirements
- R1: After reset the control word reads 0, the clock-stopped output is 1 and the serial clock is low.
- R2: The control word (register select 0) holds the primary enable at bit 0, the divider code at bits [9:8], the phase bit at bit 12 and the secondary enable at bit 16. All other bits read 0.
- R3: A write to register select 0 while the clock is not stopped updates only the two enables. Divider and phase keep their values, even when the write lands in the same cycle in which the clock stops.
- R4: With divider code d of 1, 2 or 3, the serial clock has a period of 2^d controller cycles. It is high for the first half and low for the second.
- R5: With divider code 0, the serial clock follows the controller clock: high in its high phase, low in its low phase.
- R6: After an enable is written while the clock is stopped, the stopped flag is still 1 just after the writing edge and falls at the next rising edge. For codes 1 to 3 the serial clock is high in that first cycle.
- R7: After both enables are cleared, the serial clock completes its current period and is then held low. The stopped flag rises only when the clock is parked low; no high phase is shortened.
- R8: The clock runs when either enable bit is 1.
- R9: The status word (register select 1) holds engine idle (the inverse of the busy input) at bit 3, clock-stopped at bit 4, bus reading at bit 9 and bus writing at bit 10. All other bits are 0. Writes to select 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wsel | input | 1 | Write target: 0 control, 1 status |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | 1 | Read source: 0 control, 1 status |
| reg_rdata | output | 32 | Read data |
| eng_busy | input | 1 | Transfer engine is active |
| bus_rd | input | 1 | Host bus read in progress |
| bus_wr | input | 1 | Host bus write in progress |
| sclk | output | 1 | Divided, gated serial clock |
| clk_stopped | output | 1 | Serial clock is parked and stopped |

## Verification
The critical overlap is a configuration write that arrives on the same edge on which a stop completes. Both use the stopped condition as it stood before that edge. The bench clears the enables, predicts the final count of the current period and times a divider write to land on exactly that edge. It expects the stopped flag to rise while the old divider reads back unchanged, and then expects a repeat of the write one cycle later to be accepted. The stop itself is swept over every phase of every divider code, and the serial clock is compared cycle by cycle against a period computed from the code.

// File: rtl/sclk_divider.sv
module sclk_divider (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_wsel,
  input  logic [31:0] reg_wdata,
  input  logic        reg_rsel,
  output logic [31:0] reg_rdata,
  input  logic        eng_busy,
  input  logic        bus_rd,
  input  logic        bus_wr,
  output logic        sclk,
  output logic        clk_stopped
);

  localparam int DW = 2;
  localparam int CW = (1 << DW) - 1;

  logic          en_a, en_b, ph_q, run_q, sclk_q, gate_q;
  logic [DW-1:0] div_q;
  logic [CW-1:0] cnt_q, last, nxt;
  logic          want, stp, bypass;

  assign want   = en_a | en_b;
  assign bypass = (div_q == '0);
  assign stp    = !run_q && !gate_q;
  assign last   = CW'((1 << div_q) - 1);
  assign nxt    = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_a  <= 1'b0;
      en_b  <= 1'b0;
      ph_q  <= 1'b0;
      div_q <= '0;
    end else if (reg_wr && !reg_wsel) begin
      en_a <= reg_wdata[0];
      en_b <= reg_wdata[16];
      if (stp) begin
        ph_q  <= reg_wdata[12];
        div_q <= reg_wdata[9:8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run_q) begin
      if (want && stp) begin
        run_q  <= 1'b1;
        cnt_q  <= '0;
        sclk_q <= !bypass;
      end
    end else if (bypass) begin
      if (!want) run_q <= 1'b0;
    end else if (cnt_q == last) begin
      cnt_q <= '0;
      if (!want) begin
        run_q  <= 1'b0;
        sclk_q <= 1'b0;
      end else begin
        sclk_q <= 1'b1;
      end
    end else begin
      cnt_q  <= nxt;
      sclk_q <= (nxt <= (last >> 1));
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= run_q && bypass;
  end

  assign sclk        = bypass ? (clk & gate_q) : sclk_q;
  assign clk_stopped = stp;

  logic [31:0] ctrl_word, stat_word;
  always_comb begin
    ctrl_word      = '0;
    ctrl_word[0]   = en_a;
    ctrl_word[9:8] = div_q;
    ctrl_word[12]  = ph_q;
    ctrl_word[16]  = en_b;
    stat_word      = '0;
    stat_word[3]   = !eng_busy;
    stat_word[4]   = stp;
    stat_word[9]   = bus_rd;
    stat_word[10]  = bus_wr;
  end
  assign reg_rdata = reg_rsel ? stat_word : ctrl_word;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !stp |=> ($stable(div_q) && $stable(ph_q)));  // R3
  AST_PARK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    stp |-> !sclk_q);  // R7
  AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stp) && !bypass) |-> ($past(cnt_q) == $past(last)));  // R7
  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run_q) && !bypass) |-> sclk_q);  // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= last));  // R4
  AST_RUN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(want));  // R8

endmodule

// File: tb/tb_sclk_divider.sv
`timescale 1ns/1ps
module tb_sclk_divider;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_wsel = 0, reg_rsel = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic eng_busy = 0, bus_rd = 0, bus_wr = 0;
  logic sclk, clk_stopped;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  sclk_divider dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_wsel = s; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(input logic s, output logic [31:0] v);
    reg_rsel = s; #0.5; v = reg_rdata;
  endtask

  function automatic logic pat(int j, int p);
    return (j % p) < (p / 2);
  endfunction

  task automatic run_div(int d, int k);
    int p, j;
    logic [31:0] v;
    p = 1 << d;
    wr(0, 32'h1 | (d << 8));
    chk("R6 stopped after write", clk_stopped, 1);
    @(posedge clk); #1;
    chk("R6 stopped falls", clk_stopped, 0);
    j = 0;
    if (d > 0) begin
      chk("R6 first high", sclk, 1);
      for (int i = 0; i < 2 * p + k; i++) begin
        @(posedge clk); #1; j++;
        chk("R4 period", sclk, pat(j, p));
      end
      wr(0, 0); j++;
      chk("R7 after clear", sclk, pat(j, p));
      for (int i = 0; i < p + 2; i++) begin
        int pr;
        pr = j;
        @(posedge clk); #1; j++;
        if (pr % p == p - 1) begin
          chk("R7 parked", sclk, 0);
          chk("R7 flag", clk_stopped, 1);
          break;
        end
        chk("R7 finishing", sclk, pat(j, p));
        chk("R7 flag low", clk_stopped, 0);
      end
    end else begin
      for (int i = 0; i < 3 + k; i++) begin
        @(posedge clk); #1;
        chk("R5 high", sclk, 1);
        #2;
        chk("R5 low", sclk, 0);
      end
      wr(0, 0);
      @(posedge clk); #1;
      chk("R7 full high", sclk, 1);
      chk("R7 flag low", clk_stopped, 0);
      #2;
      chk("R7 parked", sclk, 0);
      chk("R7 flag", clk_stopped, 1);
      @(posedge clk); #1;
    end
    rd(0, v);
    chk("R2 divider readback", v, d << 8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int j;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    #1;
    rd(0, v);
    chk("R1 ctrl", v, 0);
    chk("R1 stopped", clk_stopped, 1);
    chk("R1 sclk", sclk, 0);

    for (int d = 0; d < 4; d++)
      for (int k = 0; k < (1 << d) + 1; k++)
        run_div(d, k);

    wr(0, 32'hFFFF_FFFF);
    rd(0, v);
    chk("R2 all bits", v, 32'h0001_1301);
    repeat (3) @(posedge clk); #1;
    wr(0, 0);
    repeat (12) @(posedge clk); #1;
    chk("R7 stopped", clk_stopped, 1);
    rd(0, v);
    chk("R3 cfg kept", v, 32'h0000_1300);

    wr(0, 32'h0000_0101);
    @(posedge clk); #1;
    wr(0, 32'h0000_1301);
    rd(0, v);
    chk("R3 running write", v, 32'h0000_0101);
    wr(0, 32'h0001_0300);
    rd(0, v);
    chk("R8 enable swap", v, 32'h0001_0100);
    repeat (3) @(posedge clk); #1;
    chk("R8 still running", clk_stopped, 0);
    wr(0, 32'h0000_0200);
    repeat (6) @(posedge clk); #1;
    chk("R8 stopped", clk_stopped, 1);
    rd(0, v);
    chk("R3 kept div", v, 32'h0000_0100);

    wr(0, 32'h0000_0201);
    @(posedge clk); #1;
    j = 0;
    repeat (5) begin @(posedge clk); #1; j++; end
    wr(0, 32'h0000_0200); j++;
    while (j % 4 != 3) begin @(posedge clk); #1; j++; end
    wr(0, 32'h0000_0300);
    chk("R7 same-cycle stop", clk_stopped, 1);
    rd(0, v);
    chk("R3 same-cycle reject", v, 32'h0000_0200);
    wr(0, 32'h0000_0300);
    rd(0, v);
    chk("R3 accepted after", v, 32'h0000_0300);

    for (int s = 0; s < 8; s++) begin
      logic [31:0] e;
      eng_busy = s[0]; bus_rd = s[1]; bus_wr = s[2];
      rd(1, v);
      e = (32'(!s[0]) << 3) | (32'h1 << 4) | (32'(s[1]) << 9) | (32'(s[2]) << 10);
      chk("R9 status", v, e);
    end
    wr(1, 32'hFFFF_FFFF);
    rd(0, v);
    chk("R9 status write ignored", v, 32'h0000_0300);
    chk("R9 clock unaffected", clk_stopped, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule